// File: doc/BRIEF.md
# DS3 Overhead Error Injector

This block sits in the transmit path of a DS3 framer. It corrupts chosen overhead bits on purpose so that receiving equipment can be tested. The input is a serial bit stream that carries one bit per clock, together with a strobe that marks the first bit of each 4760-bit frame. The block tracks where each bit falls in the frame. At the parity, multiframe and framing overhead positions it flips the bit when a host-programmed control bit asks for it. Every other bit passes through untouched, and the output is always registered.

The frame is built from 7 subframes of 680 bits. Each subframe holds 8 blocks of 85 bits, and each block is one overhead bit followed by 84 payload bits. The eight overhead bits of a subframe come in the order X/P/M, F1, C1, F2, C2, F3, C3, F4. Subframes 1 and 2 carry X-bits, subframes 3 and 4 carry P-bits, and subframes 5 to 7 carry M-bits. The P-bit value arriving on the input has already been computed upstream from the previous frame's payload. This block only decides whether to invert it.

The host reaches the controls through a byte-wide write/read port. There is one control byte for the M- and P-bits, and four bytes of per-F-bit masks. Writes go into shadow registers. The shadow values are copied into the active set at the next frame-start strobe.

Top module: `ds3_ovh_err_inj`

## Requirements
- R1: After reset, `data_o` is 0 and every register reads 0, so no bit is altered until the host programs a mask.
- R2: When bit 3 of the control byte at address 0x35 is active, both P-bits (overhead bit of block 1 in subframes 3 and 4) leave inverted. When it is 0, they pass unchanged.
- R3: Bits 2..0 of the control byte at 0x35 are XORed into the three M-bits. Bit 2 acts on subframe 5, bit 1 on subframe 6 and bit 0 on subframe 7.
- R4: The 28 F-bit mask bits are XORed into the 28 F-bits. F-bits sit at blocks 2, 4, 6 and 8 of every subframe. Mask index 27 acts on the first F-bit of the frame (subframe 1, F1), and the index falls by one per F-bit in transmission order, down to 0 at subframe 7, F4.
- R5: Register map. 0x35 holds the control byte in bits 3..0 and reads 0 in bits 7..4. 0x36 holds mask bits 27..24 in bits 3..0 and reads 0 in bits 7..4. 0x37 holds mask bits 23..16, 0x38 holds 15..8 and 0x39 holds 7..0, each MSB-aligned. Any other address reads 0, and writes to it change nothing.
- R6: Payload bits, X-bits and C-bits are never altered.
- R7: `data_o` equals the bit applied on `data_i` one clock earlier, inverted only when a mask selects that position.
- R8: A register write takes effect from the next frame-start strobe. A write in the same cycle as a strobe waits for the strobe after it.
- R9: A strobe that arrives before the bit count reaches 4759 restarts the frame at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one stream bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | High with the first bit of a frame |
| data_i | input | 1 | Serial DS3 bit in |
| data_o | output | 1 | Serial DS3 bit out, one clock later |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |

## Verification
Each stream bit is due on `data_o` exactly one rising edge after it is applied. The bench drives each bit at a falling edge and compares the output 1 ns after the next rising edge, so every bit of every checked frame is compared in its own cycle against a position model computed in the bench. Register reads are combinational, so they are sampled within the same low phase in which the address is applied. A new mask is expected to show up only in the frame whose strobe follows the write, and the bench's expectations switch at exactly that frame boundary.

// File: rtl/ds3_inj_pkg.sv
package ds3_inj_pkg;

  // F-bits sit on odd block slots within a subframe
  function automatic logic is_f_slot(input int slot);
    return (slot % 2) == 1;
  endfunction

  // transmission-order number of an F-bit within the frame
  function automatic int f_order(input int sf, input int slot, input int f_per_sf);
    return sf * f_per_sf + slot / 2;
  endfunction

  // transmission-order number of an M-bit (0 = first M subframe)
  function automatic int m_order(input int sf, input int sfs, input int nm);
    return sf - (sfs - nm);
  endfunction

  // two P subframes directly precede the M subframes
  function automatic logic is_p_sf(input int sf, input int sfs, input int nm);
    return (sf >= sfs - nm - 2) && (sf < sfs - nm);
  endfunction

endpackage

// File: rtl/ds3_frame_pos.sv
module ds3_frame_pos #(
  parameter int BLK_BITS     = 85,
  parameter int BLKS_PER_SF  = 8,
  parameter int SF_PER_FRAME = 7,
  localparam int OW = $clog2(BLK_BITS),
  localparam int SW = $clog2(BLKS_PER_SF),
  localparam int FW = $clog2(SF_PER_FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start_i,
  output logic          cur_valid_o,
  output logic [OW-1:0] cur_offs_o,
  output logic [SW-1:0] cur_slot_o,
  output logic [FW-1:0] cur_sf_o
);

  logic [OW-1:0] prev_offs_q, n_offs;
  logic [SW-1:0] prev_slot_q, n_slot;
  logic [FW-1:0] prev_sf_q, n_sf;
  logic          sync_q;

  always_comb begin
    n_offs = prev_offs_q;
    n_slot = prev_slot_q;
    n_sf   = prev_sf_q;
    if (frame_start_i) begin
      n_offs = '0;
      n_slot = '0;
      n_sf   = '0;
    end else if (prev_offs_q == OW'(BLK_BITS - 1)) begin
      n_offs = '0;
      if (prev_slot_q == SW'(BLKS_PER_SF - 1)) begin
        n_slot = '0;
        n_sf   = (prev_sf_q == FW'(SF_PER_FRAME - 1)) ? '0 : prev_sf_q + 1'b1;
      end else begin
        n_slot = prev_slot_q + 1'b1;
      end
    end else begin
      n_offs = prev_offs_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_offs_q <= '0;
      prev_slot_q <= '0;
      prev_sf_q   <= '0;
      sync_q      <= 1'b0;
    end else begin
      prev_offs_q <= n_offs;
      prev_slot_q <= n_slot;
      prev_sf_q   <= n_sf;
      sync_q      <= sync_q | frame_start_i;
    end
  end

  assign cur_valid_o = sync_q | frame_start_i;
  assign cur_offs_o  = n_offs;
  assign cur_slot_o  = n_slot;
  assign cur_sf_o    = n_sf;

endmodule

// File: rtl/ds3_inj_regs.sv
module ds3_inj_regs #(
  parameter int          N_MBITS    = 3,
  parameter int          N_FBITS    = 28,
  parameter int          AW         = 8,
  parameter int          DW         = 8,
  parameter logic [7:0]  ADDR_MCTL  = 8'h35,
  parameter logic [7:0]  ADDR_FBASE = 8'h36,
  localparam int CTL_BITS = N_MBITS + 1,
  localparam int F_BYTES  = (N_FBITS + DW - 1) / DW,
  localparam int F_PAD    = F_BYTES * DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic               frame_start_i,
  output logic               act_perr_o,
  output logic [N_MBITS-1:0] act_m_o,
  output logic [N_FBITS-1:0] act_f_o
);

  localparam logic [F_PAD-1:0]    F_VALID   = F_PAD'({N_FBITS{1'b1}});
  localparam logic [DW-1:0]       CTL_VALID = DW'({CTL_BITS{1'b1}});

  logic [CTL_BITS-1:0] sh_ctl_q, act_ctl_q;
  logic [F_PAD-1:0]    sh_f_q;
  logic [N_FBITS-1:0]  act_f_q;

  // shadow registers, host side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_ctl_q <= '0;
      sh_f_q   <= '0;
    end else if (wr_i) begin
      if (addr_i == AW'(ADDR_MCTL))
        sh_ctl_q <= CTL_BITS'(wdata_i & CTL_VALID);
      for (int j = 0; j < F_BYTES; j++) begin
        if (addr_i == AW'(ADDR_FBASE + j))
          sh_f_q[(F_BYTES-1-j)*DW +: DW] <= wdata_i & F_VALID[(F_BYTES-1-j)*DW +: DW];
      end
    end
  end

  // active set, loaded only at a frame boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_ctl_q <= '0;
      act_f_q   <= '0;
    end else if (frame_start_i) begin
      act_ctl_q <= sh_ctl_q;
      act_f_q   <= sh_f_q[N_FBITS-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_MCTL))
      rdata_o = DW'(sh_ctl_q);
    for (int j = 0; j < F_BYTES; j++) begin
      if (addr_i == AW'(ADDR_FBASE + j))
        rdata_o = sh_f_q[(F_BYTES-1-j)*DW +: DW];
    end
  end

  assign act_perr_o = act_ctl_q[N_MBITS];
  assign act_m_o    = act_ctl_q[N_MBITS-1:0];
  assign act_f_o    = act_f_q;

endmodule

// File: rtl/ds3_ovh_sel.sv
module ds3_ovh_sel
  import ds3_inj_pkg::*;
#(
  parameter int BLK_BITS     = 85,
  parameter int BLKS_PER_SF  = 8,
  parameter int SF_PER_FRAME = 7,
  parameter int N_MBITS      = 3,
  parameter int N_FBITS      = 28,
  localparam int OW       = $clog2(BLK_BITS),
  localparam int SW       = $clog2(BLKS_PER_SF),
  localparam int FW       = $clog2(SF_PER_FRAME),
  localparam int F_PER_SF = BLKS_PER_SF / 2
) (
  input  logic               cur_valid_i,
  input  logic [OW-1:0]      cur_offs_i,
  input  logic [SW-1:0]      cur_slot_i,
  input  logic [FW-1:0]      cur_sf_i,
  input  logic               act_perr_i,
  input  logic [N_MBITS-1:0] act_m_i,
  input  logic [N_FBITS-1:0] act_f_i,
  output logic               ovh_o,
  output logic               flip_o
);

  int sfi;
  int sli;
  assign sfi = int'(cur_sf_i);
  assign sli = int'(cur_slot_i);

  assign ovh_o = cur_valid_i && (cur_offs_i == '0);

  always_comb begin
    flip_o = 1'b0;
    if (ovh_o) begin
      if (sli == 0) begin
        if (sfi >= SF_PER_FRAME - N_MBITS) begin
          for (int k = 0; k < N_MBITS; k++) begin
            if (m_order(sfi, SF_PER_FRAME, N_MBITS) == N_MBITS - 1 - k)
              flip_o = act_m_i[k];
          end
        end else if (is_p_sf(sfi, SF_PER_FRAME, N_MBITS)) begin
          flip_o = act_perr_i;
        end
      end else if (is_f_slot(sli)) begin
        for (int k = 0; k < N_FBITS; k++) begin
          if (f_order(sfi, sli, F_PER_SF) == N_FBITS - 1 - k)
            flip_o = act_f_i[k];
        end
      end
    end
  end

endmodule

// File: rtl/ds3_ovh_err_inj.sv
module ds3_ovh_err_inj #(
  parameter int          BLK_BITS     = 85,
  parameter int          BLKS_PER_SF  = 8,
  parameter int          SF_PER_FRAME = 7,
  parameter int          N_MBITS      = 3,
  parameter int          N_FBITS      = 28,
  parameter int          REG_AW       = 8,
  parameter int          REG_DW       = 8,
  parameter logic [7:0]  ADDR_MCTL    = 8'h35,
  parameter logic [7:0]  ADDR_FBASE   = 8'h36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              data_i,
  output logic              data_o,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o
);

  localparam int OW = $clog2(BLK_BITS);
  localparam int SW = $clog2(BLKS_PER_SF);
  localparam int FW = $clog2(SF_PER_FRAME);

  // named internal events, observed by the bound checker
  logic               cur_valid_w;
  logic [OW-1:0]      cur_offs_w;
  logic [SW-1:0]      cur_slot_w;
  logic [FW-1:0]      cur_sf_w;
  logic               act_perr_w;
  logic [N_MBITS-1:0] act_m_w;
  logic [N_FBITS-1:0] act_f_w;
  logic               cur_ovh_w;
  logic               flip_w;
  logic               data_q;

  ds3_frame_pos #(
    .BLK_BITS    (BLK_BITS),
    .BLKS_PER_SF (BLKS_PER_SF),
    .SF_PER_FRAME(SF_PER_FRAME)
  ) u_pos (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(frame_start_i),
    .cur_valid_o  (cur_valid_w),
    .cur_offs_o   (cur_offs_w),
    .cur_slot_o   (cur_slot_w),
    .cur_sf_o     (cur_sf_w)
  );

  ds3_inj_regs #(
    .N_MBITS   (N_MBITS),
    .N_FBITS   (N_FBITS),
    .AW        (REG_AW),
    .DW        (REG_DW),
    .ADDR_MCTL (ADDR_MCTL),
    .ADDR_FBASE(ADDR_FBASE)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (reg_wr_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .frame_start_i(frame_start_i),
    .act_perr_o   (act_perr_w),
    .act_m_o      (act_m_w),
    .act_f_o      (act_f_w)
  );

  ds3_ovh_sel #(
    .BLK_BITS    (BLK_BITS),
    .BLKS_PER_SF (BLKS_PER_SF),
    .SF_PER_FRAME(SF_PER_FRAME),
    .N_MBITS     (N_MBITS),
    .N_FBITS     (N_FBITS)
  ) u_sel (
    .cur_valid_i(cur_valid_w),
    .cur_offs_i (cur_offs_w),
    .cur_slot_i (cur_slot_w),
    .cur_sf_i   (cur_sf_w),
    .act_perr_i (act_perr_w),
    .act_m_i    (act_m_w),
    .act_f_i    (act_f_w),
    .ovh_o      (cur_ovh_w),
    .flip_o     (flip_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) data_q <= 1'b0;
    else        data_q <= data_i ^ flip_w;
  end

  assign data_o = data_q;

endmodule

// File: rtl/ds3_ovh_err_inj_chk.sv
module ds3_ovh_err_inj_chk #(
  parameter int          SF_PER_FRAME = 7,
  parameter int          N_MBITS      = 3,
  parameter int          N_FBITS      = 28,
  parameter int          OW           = 7,
  parameter int          SW           = 3,
  parameter int          FW           = 3,
  parameter int          AW           = 8,
  parameter int          DW           = 8,
  parameter logic [7:0]  ADDR_FBASE   = 8'h36
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start_i,
  input logic               data_i,
  input logic               data_o,
  input logic [AW-1:0]      reg_addr_i,
  input logic [DW-1:0]      reg_rdata_o,
  input logic               cur_ovh_w,
  input logic [OW-1:0]      cur_offs_w,
  input logic [SW-1:0]      cur_slot_w,
  input logic [FW-1:0]      cur_sf_w,
  input logic               flip_w,
  input logic               act_perr_w,
  input logic [N_MBITS-1:0] act_m_w,
  input logic [N_FBITS-1:0] act_f_w
);

  localparam int X_SFS = SF_PER_FRAME - N_MBITS - 2;

  // R7: untouched bits come out one clock later unchanged
  a_r7_pass_delay: assert property (@(posedge clk) disable iff (!rst_n)
    !flip_w |=> (data_o == $past(data_i)));

  // R7: selected bits come out one clock later inverted
  a_r7_flip_delay: assert property (@(posedge clk) disable iff (!rst_n)
    flip_w |=> (data_o != $past(data_i)));

  // R6: payload positions never flip
  a_r6_payload_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_ovh_w |-> !flip_w);

  // R6: C-bit slots never flip
  a_r6_cbit_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ovh_w && (cur_slot_w != '0) && !cur_slot_w[0]) |-> !flip_w);

  // R6: X-bit slots never flip
  a_r6_xbit_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ovh_w && (cur_slot_w == '0) && (cur_sf_w < FW'(X_SFS))) |-> !flip_w);

  // R1: with no active mask nothing flips
  a_r1_idle_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_perr_w && (act_m_w == '0) && (act_f_w == '0)) |-> !flip_w);

  // R8: active masks change only at a frame strobe
  a_r8_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> ($stable(act_m_w) && $stable(act_f_w) && $stable(act_perr_w)));

  // R9: the bit after a strobe is offset 1 of block 1 unless another strobe arrives
  a_r9_resync: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (frame_start_i || ((cur_offs_w == OW'(1)) && (cur_slot_w == '0) && (cur_sf_w == '0))));

  // R5: upper nibble of the first F-mask byte always reads zero
  a_r5_fbyte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == AW'(ADDR_FBASE)) |-> (reg_rdata_o[DW-1:4] == '0));

endmodule

bind ds3_ovh_err_inj ds3_ovh_err_inj_chk #(
  .SF_PER_FRAME(SF_PER_FRAME),
  .N_MBITS     (N_MBITS),
  .N_FBITS     (N_FBITS),
  .OW          (OW),
  .SW          (SW),
  .FW          (FW),
  .AW          (REG_AW),
  .DW          (REG_DW),
  .ADDR_FBASE  (ADDR_FBASE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_start_i(frame_start_i),
  .data_i       (data_i),
  .data_o       (data_o),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .cur_ovh_w    (cur_ovh_w),
  .cur_offs_w   (cur_offs_w),
  .cur_slot_w   (cur_slot_w),
  .cur_sf_w     (cur_sf_w),
  .flip_w       (flip_w),
  .act_perr_w   (act_perr_w),
  .act_m_w      (act_m_w),
  .act_f_w      (act_f_w)
);

// File: tb/ds3_ovh_err_inj_tb.sv
`timescale 1ns/1ps
module ds3_ovh_err_inj_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start_i = 1'b0;
  logic       data_i = 1'b0;
  logic       data_o;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_addr_i = 8'h00;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;

  int checks = 0;
  int errors = 0;

  localparam int FRAME = 4760;
  localparam int NV    = 5;

  // vector table: control nibble, F mask, data seed
  localparam logic [3:0]  TBL_M [NV] = '{4'h0, 4'h8, 4'h5, 4'h2, 4'hF};
  localparam logic [27:0] TBL_F [NV] = '{28'h0000000, 28'h0000000, 28'h8000001,
                                         28'h5A5A5A5, 28'hFFFFFFF};
  localparam int          TBL_S [NV] = '{1, 2, 3, 4, 5};

  always #5 clk = ~clk;

  ds3_ovh_err_inj u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(frame_start_i),
    .data_i       (data_i),
    .data_o       (data_o),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected inversion from the frame layout in the requirements
  function automatic logic exp_flip(input int p, input logic [3:0] m, input logic [27:0] f);
    int off, blk, sf, sl;
    off = p % 85;
    blk = p / 85;
    sf  = blk / 8;
    sl  = blk % 8;
    if (off != 0) return 1'b0;
    if (sl == 0) begin
      if (sf == 2 || sf == 3) return m[3];
      if (sf >= 4) return m[6 - sf];
      return 1'b0;
    end
    if (sl % 2 == 1) return f[27 - (sf * 4 + sl / 2)];
    return 1'b0;
  endfunction

  function automatic logic pat(input int p, input int seed);
    int v;
    v = p * 13 + seed * 7 + (p >> 3);
    return v[0] ^ v[4];
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    frame_start_i = 1'b0;
    reg_wr_i = 1'b1;
    reg_addr_i = a;
    reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic prog(input logic [3:0] m, input logic [27:0] f);
    wr(8'h35, {4'h0, m});
    wr(8'h36, {4'h0, f[27:24]});
    wr(8'h37, f[23:16]);
    wr(8'h38, f[15:8]);
    wr(8'h39, f[7:0]);
  endtask

  // drive len bits starting with a strobe; compare each output one edge later
  task automatic run_frame(input int len, input logic [3:0] m, input logic [27:0] f,
                           input int seed, input int wr_at, input logic [7:0] wa,
                           input logic [7:0] wd, input string req);
    int bad, first;
    logic got, expv, fexp;
    bad = 0;
    first = -1;
    fexp = 1'b0;
    got = 1'b0;
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      frame_start_i = (p == 0);
      data_i = pat(p, seed);
      reg_wr_i = (p == wr_at);
      if (p == wr_at) begin
        reg_addr_i = wa;
        reg_wdata_i = wd;
      end
      expv = data_i ^ exp_flip(p, m, f);
      @(posedge clk);
      #1;
      if (data_o !== expv) begin
        if (bad == 0) begin
          first = p;
          got = data_o;
          fexp = expv;
        end
        bad++;
      end
    end
    check(bad == 0, $sformatf("%s bitpos=%0d mismatches=%0d", req, first, bad),
          32'(got), 32'(fexp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;

    // R1: reset state
    repeat (4) @(posedge clk);
    #1;
    check(data_o == 1'b0, "R1 data_o in reset", 32'(data_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 8'h35; a <= 8'h39; a++) begin
      rd(8'(a), r);
      check(r == 8'h00, $sformatf("R1 reset read addr %0h", a), 32'(r), 0);
    end

    // R5: field widths and unmapped addresses
    wr(8'h36, 8'hFF);
    rd(8'h36, r);
    check(r == 8'h0F, "R5 F byte 0x36 upper nibble", 32'(r), 32'h0F);
    wr(8'h35, 8'hFF);
    rd(8'h35, r);
    check(r == 8'h0F, "R5 control byte 0x35 upper nibble", 32'(r), 32'h0F);
    wr(8'h3A, 8'hA5);
    rd(8'h3A, r);
    check(r == 8'h00, "R5 unmapped 0x3A", 32'(r), 0);
    wr(8'h34, 8'hA5);
    rd(8'h34, r);
    check(r == 8'h00, "R5 unmapped 0x34", 32'(r), 0);
    prog(4'h0, 28'h0);

    // table walk: R1 R2 R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      prog(TBL_M[i], TBL_F[i]);
      rd(8'h35, r);
      check(r == {4'h0, TBL_M[i]}, $sformatf("R5 vec %0d read 0x35", i), 32'(r), 32'(TBL_M[i]));
      rd(8'h36, r);
      check(r == {4'h0, TBL_F[i][27:24]}, $sformatf("R5 vec %0d read 0x36", i), 32'(r),
            32'(TBL_F[i][27:24]));
      rd(8'h37, r);
      check(r == TBL_F[i][23:16], $sformatf("R5 vec %0d read 0x37", i), 32'(r),
            32'(TBL_F[i][23:16]));
      rd(8'h38, r);
      check(r == TBL_F[i][15:8], $sformatf("R5 vec %0d read 0x38", i), 32'(r),
            32'(TBL_F[i][15:8]));
      rd(8'h39, r);
      check(r == TBL_F[i][7:0], $sformatf("R5 vec %0d read 0x39", i), 32'(r),
            32'(TBL_F[i][7:0]));
      run_frame(FRAME, TBL_M[i], TBL_F[i], TBL_S[i], -1, 8'h00, 8'h00,
                $sformatf("R1 R2 R3 R4 R6 R7 vec %0d", i));
    end

    // R8: mid-frame write leaves current frame alone
    run_frame(FRAME, 4'hF, 28'hFFFFFFF, 6, 200, 8'h35, 8'h00, "R8 mid-frame write held");
    run_frame(FRAME, 4'h0, 28'hFFFFFFF, 7, -1, 8'h00, 8'h00, "R8 write active next frame");
    // R8: write in the strobe cycle waits one more frame
    run_frame(FRAME, 4'h0, 28'hFFFFFFF, 8, 0, 8'h39, 8'h00, "R8 strobe-cycle write held");
    run_frame(FRAME, 4'h0, 28'hFFFFF00, 9, -1, 8'h00, 8'h00, "R8 strobe-cycle write applied");

    // R9: early strobe restarts at bit 0 (back to back, no idle bit)
    prog(4'hA, 28'h9249249);
    run_frame(1500, 4'hA, 28'h9249249, 10, -1, 8'h00, 8'h00, "R9 partial frame");
    run_frame(FRAME, 4'hA, 28'h9249249, 11, -1, 8'h00, 8'h00, "R9 resync after early strobe");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule